// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a free-running watchdog that a processor controls through a small word-addressed register bus. Software arms it, feeds it, and unlocks its timing registers by writing fixed 16-bit codes to a key register. Once armed it cannot be disarmed. A 12-bit down-counter is clocked by a divided tick. When the counter runs out, the block raises a one-cycle reset request towards the system reset controller.

New prescaler and reload values do not reach the counting logic at once. Each is held in a shadow register and copied across only after a fixed number of divided ticks. Two status bits report that a copy is still in flight. An optional window register can also be set. When the window is active, a refresh that comes while the counter is still above the window value counts as a fault and raises the reset request.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, rst_req is low and the registers read as follows: key (word 0) 0, prescaler (word 1) 0, reload (word 2) 0xFFF, status (word 3) 0, window (word 4) 0xFFF.
- R2: If the registers are locked, writes to the prescaler, reload and window words are ignored. Their read-back values and the status word stay unchanged.
- R3: Writing 0x5555 to the low 16 bits of the key word unlocks the prescaler, reload and window words. Writing any other key value locks them again.
- R4: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. Each bit clears once SYNC_TICKS divided ticks have passed, and only then does the new value take effect.
- R5: Key 0xCCCC starts the watchdog with prescaler code p and reload value r. The first rst_req then comes more than 4·2^p·r and at most 4·2^p·(r+1)+2 clock cycles after the start write.
- R6: Every prescaler code of 6 or above divides the clock by 256.
- R7: Key 0xAAAA reloads the counter with the active reload value, which pushes the timeout back by a full period measured from the refresh.
- R8: If the window value is not 0xFFF, a refresh written while the counter is above the window value raises rst_req on the next cycle. A refresh written while the counter is at or below the window value reloads the counter.
- R9: rst_req is a single-cycle pulse. After it fires, counting stops and no further pulse comes until the next reset.
- R10: Once started, the watchdog cannot be stopped. Key writes of other values do not prevent the timeout.
- R11: Before the start key is written, rst_req stays low no matter how long the block runs, and refresh keys have no effect.
- R12: The key word, unused addresses 5 to 7 and all unused register bits read as zero. The prescaler keeps bits [2:0] and the reload keeps bits [11:0] of a written word. Reads return one cycle after the request, with rd_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counting tick is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word index of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | High one cycle after a read access |
| rst_req | output | 1 | One-cycle reset request on timeout or window fault |

## Verification
The bench uses the default parameters: a 3-bit prescaler code clamped at shift 6, a 12-bit reload, a 32-bit data word and SYNC_TICKS of 5. Because reload values are programmed through the bus, small values such as 1, 3, 9 and 100 bring timeouts down to tens or hundreds of cycles. That makes the clamp of codes 6 and 7 to divide-by-256 measurable next to the 4- and 16-cycle dividers. The pending-flag delay is timed at the fastest divider, where five ticks take about twenty cycles. Window faults are reached with a reload of 100 against a window of 50.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [15:0] KEY_ARM    = 16'hCCCC;
  localparam logic [15:0] KEY_OPEN   = 16'h5555;
  localparam logic [15:0] KEY_FEED   = 16'hAAAA;

  localparam int ADDR_KEY  = 0;
  localparam int ADDR_DIV  = 1;
  localparam int ADDR_RLD  = 2;
  localparam int ADDR_STAT = 3;
  localparam int ADDR_WIN  = 4;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int AW         = 3,
  parameter int DW         = 32,
  parameter int PR_W       = 3,
  parameter int RL_W       = 12,
  parameter int SYNC_TICKS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            tick,
  output logic [DW-1:0]   bus_rdata,
  output logic            rd_valid,
  output logic [PR_W-1:0] pr_act,
  output logic [RL_W-1:0] rl_act,
  output logic [RL_W-1:0] win_val,
  output logic [1:0]      pend,
  output logic            arm_key,
  output logic            feed_key
);
  localparam int SW  = $clog2(SYNC_TICKS + 1);
  localparam int NCH = 2;

  logic            wr_key, wr_div, wr_rld, wr_win;
  logic            unlocked;
  logic [15:0]     key_val;
  logic [PR_W-1:0] pr_sh;
  logic [RL_W-1:0] rl_sh;
  logic [NCH-1:0]  load_ch, done_ch;

  assign key_val  = bus_wdata[15:0];
  assign wr_key   = bus_sel && bus_wr && (bus_addr == AW'(ADDR_KEY));
  assign wr_div   = bus_sel && bus_wr && (bus_addr == AW'(ADDR_DIV));
  assign wr_rld   = bus_sel && bus_wr && (bus_addr == AW'(ADDR_RLD));
  assign wr_win   = bus_sel && bus_wr && (bus_addr == AW'(ADDR_WIN));
  assign arm_key  = wr_key && (key_val == KEY_ARM);
  assign feed_key = wr_key && (key_val == KEY_FEED);
  assign load_ch  = {wr_rld && unlocked, wr_div && unlocked};

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      pr_sh    <= '0;
      rl_sh    <= '1;
      win_val  <= '1;
    end else begin
      if (wr_key) unlocked <= (key_val == KEY_OPEN);
      if (load_ch[0]) pr_sh <= bus_wdata[PR_W-1:0];
      if (load_ch[1]) rl_sh <= bus_wdata[RL_W-1:0];
      if (wr_win && unlocked) win_val <= bus_wdata[RL_W-1:0];
    end
  end

  // One transfer tracker per shadowed register
  for (genvar ch = 0; ch < NCH; ch++) begin : g_xfer
    logic          busy;
    logic [SW-1:0] seen;
    always_ff @(posedge clk) begin
      if (rst) begin
        busy <= 1'b0;
        seen <= '0;
      end else if (load_ch[ch]) begin
        busy <= 1'b1;
        seen <= '0;
      end else if (busy && tick) begin
        if (seen == SW'(SYNC_TICKS - 1)) busy <= 1'b0;
        else seen <= seen + 1'b1;
      end
    end
    assign done_ch[ch] = busy && tick && !load_ch[ch] && (seen == SW'(SYNC_TICKS - 1));
    assign pend[ch]    = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_act <= '0;
      rl_act <= '1;
    end else begin
      if (done_ch[0]) pr_act <= pr_sh;
      if (done_ch[1]) rl_act <= rl_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      rd_valid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          AW'(ADDR_DIV):  bus_rdata <= DW'(pr_sh);
          AW'(ADDR_RLD):  bus_rdata <= DW'(rl_sh);
          AW'(ADDR_STAT): bus_rdata <= DW'(pend);
          AW'(ADDR_WIN):  bus_rdata <= DW'(win_val);
          default:        bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdg_presc.sv
module wdg_presc #(
  parameter int PR_W      = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PR_W-1:0] pr_act,
  output logic            tick
);
  localparam int CW = MAX_SHIFT + 2;

  logic [PR_W-1:0] sh;
  logic [CW:0]     div;
  logic [CW-1:0]   lim, pc;

  assign sh   = (pr_act > PR_W'(MAX_SHIFT)) ? PR_W'(MAX_SHIFT) : pr_act;
  assign div  = (CW + 1)'(4) << sh;
  assign lim  = CW'(div - (CW + 1)'(1));
  assign tick = (pc >= lim);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + 1'b1;
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int RL_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            arm_key,
  input  logic            feed_key,
  input  logic [RL_W-1:0] rl_act,
  input  logic [RL_W-1:0] win_val,
  output logic            running,
  output logic            fired,
  output logic [RL_W-1:0] cnt,
  output logic            rst_req
);
  logic win_on;
  assign win_on = (win_val != '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      fired   <= 1'b0;
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (arm_key && !running) begin
        running <= 1'b1;
        cnt     <= rl_act;
      end else if (running && !fired) begin
        if (feed_key) begin
          if (win_on && (cnt > win_val)) begin
            rst_req <= 1'b1;
            fired   <= 1'b1;
          end else begin
            cnt <= rl_act;
          end
        end else if (tick) begin
          if (cnt == '0) begin
            rst_req <= 1'b1;
            fired   <= 1'b1;
            cnt     <= rl_act;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int AW         = 3,
  parameter int DW         = 32,
  parameter int PR_W       = 3,
  parameter int RL_W       = 12,
  parameter int MAX_SHIFT  = 6,
  parameter int SYNC_TICKS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rd_valid,
  output logic          rst_req
);
  logic            tick, arm_key, feed_key, running, fired;
  logic [PR_W-1:0] pr_act;
  logic [RL_W-1:0] rl_act, win_val, cnt;
  logic [1:0]      pend;

  wdg_regs #(.AW(AW), .DW(DW), .PR_W(PR_W), .RL_W(RL_W), .SYNC_TICKS(SYNC_TICKS)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tick(tick), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
    .pr_act(pr_act), .rl_act(rl_act), .win_val(win_val), .pend(pend),
    .arm_key(arm_key), .feed_key(feed_key)
  );

  wdg_presc #(.PR_W(PR_W), .MAX_SHIFT(MAX_SHIFT)) u_presc (
    .clk(clk), .rst(rst), .pr_act(pr_act), .tick(tick)
  );

  wdg_count #(.RL_W(RL_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .arm_key(arm_key), .feed_key(feed_key),
    .rl_act(rl_act), .win_val(win_val), .running(running), .fired(fired),
    .cnt(cnt), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int DW   = 32,
  parameter int RL_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            rst_req,
  input logic            running,
  input logic            fired,
  input logic            tick,
  input logic            feed_key,
  input logic [RL_W-1:0] cnt,
  input logic [1:0]      pend,
  input logic            rd_valid,
  input logic [DW-1:0]   bus_rdata
);
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_silent_after_fire_r9: assert property (@(posedge clk) disable iff (rst)
    fired |=> !rst_req);

  p_req_needs_arm_r11: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(running));

  p_no_disarm_r10: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (running && !fired && tick && !feed_key && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_div_xfer_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pend[0]) |-> $past(tick));

  p_rld_xfer_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pend[1]) |-> $past(tick));

  p_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (bus_rdata[DW-1:16] == '0));
endmodule

bind keyed_wdog wdg_checker #(.DW(DW), .RL_W(RL_W)) u_chk (
  .clk(clk), .rst(rst), .rst_req(rst_req), .running(running), .fired(fired),
  .tick(tick), .feed_key(feed_key), .cnt(cnt), .pend(pend),
  .rd_valid(rd_valid), .bus_rdata(bus_rdata)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int AW = 3;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          rd_valid;
  logic          rst_req;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
    bit            dc;
  } rd_item_t;
  rd_item_t rdq[$];

  always #5 clk = ~clk;

  keyed_wdog dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rst_req(rst_req)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rdq.size() == 0) begin
        check(1'b0, "R12 unexpected read data", bus_rdata, 0);
      end else begin
        rd_item_t it;
        it = rdq.pop_front();
        if (!it.dc) check(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [DW-1:0] e, input string tag, input bit dc);
    rd_item_t it;
    it.exp = e; it.tag = tag; it.dc = dc;
    rdq.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_status_clear(output int cyc);
    cyc = 0;
    do begin
      bus_read(3, 0, "", 1'b1);
      cyc += 1;
    end while (bus_rdata[1:0] != 2'b00 && cyc < 3000);
  endtask

  task automatic setup(input int pr, input int rl);
    int c;
    bus_write(0, 32'h5555);
    bus_write(1, DW'(pr));
    bus_write(2, DW'(rl));
    wait_status_clear(c);
  endtask

  task automatic wait_req(input int maxc, output int n);
    n = 0;
    while (!rst_req && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_timeout(input int d, input int r, input int n, input string tag);
    check((n > d * r) && (n <= d * (r + 1) + 2), tag, n, d * (r + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, c;
    do_reset();

    // R1 reset state
    check(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
    bus_read(0, 0,     "R1 key reads 0", 1'b0);
    bus_read(1, 0,     "R1 prescaler reset", 1'b0);
    bus_read(2, 12'hFFF, "R1 reload reset", 1'b0);
    bus_read(3, 0,     "R1 status reset", 1'b0);
    bus_read(4, 12'hFFF, "R1 window reset", 1'b0);

    // R2 locked writes ignored
    bus_write(1, 3);
    bus_write(2, 12'h123);
    bus_write(4, 12'h010);
    bus_read(1, 0,       "R2 locked prescaler", 1'b0);
    bus_read(2, 12'hFFF, "R2 locked reload", 1'b0);
    bus_read(4, 12'hFFF, "R2 locked window", 1'b0);
    bus_read(3, 0,       "R2 status untouched", 1'b0);

    // R3 unlock then relock by other key
    bus_write(0, 32'h5555);
    bus_write(0, 32'h1234);
    bus_write(2, 12'h005);
    bus_read(2, 12'hFFF, "R3 relocked reload", 1'b0);
    bus_write(0, 32'h5555);
    bus_write(2, 32'hFFFF_F005);
    bus_read(2, 12'h005, "R3 unlocked reload R12 masked", 1'b0);
    wait_status_clear(c);

    // R4 pending flags
    bus_write(1, 0);
    bus_read(3, 1, "R4 prescaler pending", 1'b0);
    wait_status_clear(c);
    check(c >= 8 && c < 100, "R4 prescaler transfer time", c, 10);
    bus_write(2, 9);
    bus_read(3, 2, "R4 reload pending", 1'b0);
    wait_status_clear(c);
    check(c >= 8 && c < 100, "R4 reload transfer time", c, 10);

    // R12 masking and unused addresses
    bus_write(1, 32'hFFFF_FFFF);
    bus_read(1, 7, "R12 prescaler masked", 1'b0);
    bus_read(5, 0, "R12 addr 5 zero", 1'b0);
    bus_read(6, 0, "R12 addr 6 zero", 1'b0);
    bus_read(7, 0, "R12 addr 7 zero", 1'b0);
    wait_status_clear(c);

    // R11 no request before arm, feeds ignored
    do_reset();
    setup(0, 2);
    bus_write(0, 32'hAAAA);
    wait_req(3000, n);
    check(rst_req == 1'b0, "R11 no request while idle", rst_req, 0);

    // R5 timeout divider 4
    do_reset();
    setup(0, 9);
    bus_write(0, 32'hCCCC);
    wait_req(2000, n);
    check_timeout(4, 9, n, "R5 timeout pr0 rl9");
    @(negedge clk);
    check(rst_req == 1'b0, "R9 pulse width one", rst_req, 0);
    wait_req(2000, n);
    check(rst_req == 1'b0, "R9 no second pulse", rst_req, 0);

    // R5 timeout divider 16
    do_reset();
    setup(2, 4);
    bus_write(0, 32'hCCCC);
    wait_req(2000, n);
    check_timeout(16, 4, n, "R5 timeout pr2 rl4");

    // R6 clamp codes 6 and 7
    do_reset();
    setup(7, 3);
    bus_write(0, 32'hCCCC);
    wait_req(3000, n);
    check_timeout(256, 3, n, "R6 code 7 divides by 256");
    do_reset();
    setup(6, 3);
    bus_write(0, 32'hCCCC);
    wait_req(3000, n);
    check_timeout(256, 3, n, "R6 code 6 divides by 256");

    // R7 refresh delays timeout
    do_reset();
    setup(0, 9);
    bus_write(0, 32'hCCCC);
    repeat (30) @(negedge clk);
    bus_write(0, 32'hAAAA);
    wait_req(2000, n);
    check_timeout(4, 9, n, "R7 period restarts at refresh");

    // R10 other keys cannot stop it
    do_reset();
    setup(0, 9);
    bus_write(0, 32'hCCCC);
    bus_write(0, 32'h0000);
    bus_write(0, 32'h5555);
    bus_write(0, 32'hCCCC);
    wait_req(2000, n);
    check(rst_req == 1'b1 && n <= 42, "R10 still times out", n, 40);

    // R8 early refresh inside window
    do_reset();
    setup(0, 100);
    bus_write(0, 32'h5555);
    bus_write(4, 50);
    bus_read(4, 50, "R8 window written", 1'b0);
    bus_write(0, 32'hCCCC);
    bus_write(0, 32'hAAAA);
    check(rst_req == 1'b1, "R8 early refresh faults", rst_req, 1);

    // R8 late refresh accepted
    do_reset();
    setup(0, 100);
    bus_write(0, 32'h5555);
    bus_write(4, 50);
    bus_write(0, 32'hCCCC);
    repeat (260) @(negedge clk);
    bus_write(0, 32'hAAAA);
    check(rst_req == 1'b0, "R8 late refresh accepted", rst_req, 0);
    wait_req(2000, n);
    check_timeout(4, 100, n, "R8 reload after late refresh");

    repeat (4) @(negedge clk);
    check(rdq.size() == 0, "R12 all reads returned", rdq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule